// File: doc/BRIEF.md
# Chunk-Serial Mantissa Add/Subtract Stage

This block is one macro-stage of a variable-precision floating-point pipeline. It takes two mantissas that an earlier stage has already aligned to a common binary point and adds or subtracts them 64 bits at a time. A carry or borrow register links each step to the next. Each operand comes with a small header: how many 64-bit chunks it uses, the integer bits above the binary point, and guard bits that sit just below its last used chunk. Chunk 0 is the most significant chunk. The stage works from the least significant column upward, so its latency grows with the longer operand.

A working-precision value is sampled at the moment an operation is accepted. It caps the number of chunks the result keeps. Columns below that cap are not emitted. The first discarded column gives the result guard bits, and everything below it folds into one sticky bit. Normalization and rounding happen in later stages. Both sides of the stage use ready/valid handshakes, and the stage holds one operation at a time.

Top module: `chunk_serial_adder`

## Requirements
- R1: While reset is held and on the first cycle after it, `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_sub`=0 the result equals A+B over the columns. Each operand is its integer bits, then chunks 0..len-1, where input chunk i is `in_mant_x[64*i +: 64]`. A carry out of chunk 0 adds into the result integer bits, modulo 2^IB_W.
- R3: With `in_sub`=1 the result is A-B, with a borrow passed between columns, for operands where A ≥ B.
- R4: Operand lengths may differ. The working length n is the larger of the two. An operand's guard bits occupy the top GUARD_W bits of the column just below its last chunk, and all of its other bits below its last chunk are zero.
- R5: `out_len` = min(n, max(wp,1)), where wp is the `in_wp` value at the accepting edge. Later changes of `in_wp` or of the operand inputs have no effect on the result.
- R6: `out_guard` is the top GUARD_W bits of result column `out_len`. `out_sticky` is the OR of every result bit below those guard bits. Output chunks at index ≥ `out_len` are zero.
- R7: `out_valid` rises exactly n+1 clock cycles after the accepting edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, all outputs hold steady and `in_ready` stays 0. `in_ready` is 0 from acceptance until the result is taken.
- R9: The cycle after an output handshake, `in_ready` is 1 and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are offered |
| in_ready | output | 1 | Stage can accept operands |
| in_sub | input | 1 | 1 selects A-B, 0 selects A+B |
| in_wp | input | LEN_W (4) | Working precision in chunks, sampled at acceptance |
| in_len_a | input | LEN_W (4) | Chunks used by operand A (1..MAX_CHUNKS) |
| in_len_b | input | LEN_W (4) | Chunks used by operand B (1..MAX_CHUNKS) |
| in_ib_a | input | IB_W (2) | Integer bits of A |
| in_ib_b | input | IB_W (2) | Integer bits of B |
| in_guard_a | input | GUARD_W (8) | Guard bits of A |
| in_guard_b | input | GUARD_W (8) | Guard bits of B |
| in_mant_a | input | CHUNK_W*MAX_CHUNKS (512) | Mantissa chunks of A |
| in_mant_b | input | CHUNK_W*MAX_CHUNKS (512) | Mantissa chunks of B |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Downstream takes the result |
| out_len | output | LEN_W (4) | Clamped result length |
| out_ib | output | IB_W (2) | Result integer bits |
| out_guard | output | GUARD_W (8) | Result guard bits |
| out_sticky | output | 1 | OR of all discarded bits below the guard |
| out_mant | output | CHUNK_W*MAX_CHUNKS (512) | Result chunks, unused ones zero |

## Verification
The bench drives carry chains that run from the lowest column all the way into the integer bits. It also drives borrow chains under a leading one, which a design with a wrong carry seed or wrong column order would corrupt in the top chunks. It pairs operands of unequal length, so each guard field lands inside the other operand's column. It uses working-precision values of 0, below n and above n. A design that misplaced the guard, kept a stale clamp or dropped sticky bits would report the wrong length, guard or sticky. It holds `out_ready` low for long random stretches and changes `in_wp` and the operands right after acceptance. This catches a stage that lets its output drift, accepts new work too early, or reads the precision late. Every cycle is compared with a behavioural model whose latency is counted as n+1, so one step too many or too few shows up at once.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Default geometry of the stage; the top module exposes each as a parameter.
    localparam int unsigned DEF_CHUNK_W    = 64;
    localparam int unsigned DEF_MAX_CHUNKS = 8;
    localparam int unsigned DEF_IB_W       = 2;
    localparam int unsigned DEF_GUARD_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for operands
        ST_RUN  = 2'd1,   // iterating over columns, low to high
        ST_HOLD = 2'd2    // result presented downstream
    } csa_state_e;

    // Working length: the longer of the two operands.
    function automatic int unsigned wider_len(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Output length: working length capped by the working precision (never below one).
    function automatic int unsigned clamp_len(int unsigned n, int unsigned wp);
        int unsigned lim;
        lim = (wp == 0) ? 1 : wp;
        return (n < lim) ? n : lim;
    endfunction

endpackage

// File: rtl/csa_opbuf.sv
// Input synchronisation buffer for one operand: header, integer bits, guard
// bits and the chunk memory. Presents one aligned 64-bit column per slot.
module csa_opbuf #(
    parameter int unsigned CHUNK_W    = 64,
    parameter int unsigned MAX_CHUNKS = 8,
    parameter int unsigned IB_W       = 2,
    parameter int unsigned GUARD_W    = 8,
    parameter int unsigned LEN_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [LEN_W-1:0]              ld_len,
    input  logic [IB_W-1:0]               ld_ib,
    input  logic [GUARD_W-1:0]            ld_guard,
    input  logic [CHUNK_W*MAX_CHUNKS-1:0] ld_mant,
    input  logic [LEN_W-1:0]              slot,
    output logic [CHUNK_W-1:0]            col,
    output logic [IB_W-1:0]               ib
);
    localparam int unsigned PAD_W = CHUNK_W - GUARD_W;

    logic [LEN_W-1:0]   len_q;
    logic [IB_W-1:0]    ib_q;
    logic [GUARD_W-1:0] guard_q;
    logic [CHUNK_W-1:0] mem_q [MAX_CHUNKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q   <= '0;
            ib_q    <= '0;
            guard_q <= '0;
            for (int k = 0; k < int'(MAX_CHUNKS); k++) mem_q[k] <= '0;
        end else if (load) begin
            len_q   <= ld_len;
            ib_q    <= ld_ib;
            guard_q <= ld_guard;
            for (int k = 0; k < int'(MAX_CHUNKS); k++)
                mem_q[k] <= ld_mant[k*CHUNK_W +: CHUNK_W];
        end
    end

    // Column at a slot: a used chunk, the guard field just below the last
    // used chunk, or zero.
    always_comb begin
        col = '0;
        for (int k = 0; k < int'(MAX_CHUNKS); k++) begin
            if ((LEN_W'(k) == slot) && (LEN_W'(k) < len_q)) col = mem_q[k];
        end
        if (slot == len_q) col = {guard_q, {PAD_W{1'b0}}};
    end

    assign ib = ib_q;

endmodule

// File: rtl/csa_colsum.sv
// One column of the serial adder: a + b (or a + ~b) with carry in and out.
module csa_colsum #(
    parameter int unsigned W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, (sub ? ~b : b)} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
    end

endmodule

// File: rtl/csa_resbuf.sv
// Output buffer holding the kept result chunks; cleared when a new operation
// is accepted so that chunks beyond the clamped length read as zero.
module csa_resbuf #(
    parameter int unsigned CHUNK_W    = 64,
    parameter int unsigned MAX_CHUNKS = 8,
    parameter int unsigned LEN_W      = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic                          we,
    input  logic [LEN_W-1:0]              slot,
    input  logic [CHUNK_W-1:0]            data,
    output logic [CHUNK_W*MAX_CHUNKS-1:0] flat
);
    logic [CHUNK_W-1:0] mem_q [MAX_CHUNKS];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int k = 0; k < int'(MAX_CHUNKS); k++) mem_q[k] <= '0;
        end else if (we) begin
            for (int k = 0; k < int'(MAX_CHUNKS); k++)
                if (LEN_W'(k) == slot) mem_q[k] <= data;
        end
    end

    for (genvar g = 0; g < int'(MAX_CHUNKS); g++) begin : g_flat
        assign flat[g*CHUNK_W +: CHUNK_W] = mem_q[g];
    end

endmodule

// File: rtl/chunk_serial_adder.sv
module chunk_serial_adder #(
    parameter int unsigned CHUNK_W    = csa_pkg::DEF_CHUNK_W,
    parameter int unsigned MAX_CHUNKS = csa_pkg::DEF_MAX_CHUNKS,
    parameter int unsigned IB_W       = csa_pkg::DEF_IB_W,
    parameter int unsigned GUARD_W    = csa_pkg::DEF_GUARD_W,
    localparam int unsigned LEN_W     = $clog2(MAX_CHUNKS + 1),
    localparam int unsigned MANT_W    = CHUNK_W * MAX_CHUNKS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_sub,
    input  logic [LEN_W-1:0]   in_wp,
    input  logic [LEN_W-1:0]   in_len_a,
    input  logic [LEN_W-1:0]   in_len_b,
    input  logic [IB_W-1:0]    in_ib_a,
    input  logic [IB_W-1:0]    in_ib_b,
    input  logic [GUARD_W-1:0] in_guard_a,
    input  logic [GUARD_W-1:0] in_guard_b,
    input  logic [MANT_W-1:0]  in_mant_a,
    input  logic [MANT_W-1:0]  in_mant_b,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LEN_W-1:0]   out_len,
    output logic [IB_W-1:0]    out_ib,
    output logic [GUARD_W-1:0] out_guard,
    output logic               out_sticky,
    output logic [MANT_W-1:0]  out_mant
);
    import csa_pkg::*;

    localparam int unsigned LOW_W = CHUNK_W - GUARD_W;

    csa_state_e         state_q;
    logic [LEN_W-1:0]   slot_q;     // column being processed (n down to 0)
    logic [LEN_W-1:0]   lout_q;     // clamped output length
    logic               sub_q;
    logic               carry_q;
    logic [GUARD_W-1:0] guard_q;
    logic               sticky_q;
    logic [IB_W-1:0]    ib_q;

    logic               accept;
    logic [LEN_W-1:0]   n_in;
    logic [LEN_W-1:0]   lout_in;

    // Operand side arrays so both buffers come from one generate loop.
    logic [LEN_W-1:0]   op_len   [2];
    logic [IB_W-1:0]    op_ib_in [2];
    logic [GUARD_W-1:0] op_guard [2];
    logic [MANT_W-1:0]  op_mant  [2];
    logic [CHUNK_W-1:0] op_col   [2];
    logic [IB_W-1:0]    op_ib    [2];

    logic [CHUNK_W-1:0] col_sum;
    logic               col_cout;
    logic [IB_W-1:0]    ib_sum;
    logic               discard;
    logic               res_we;

    assign op_len[0]   = in_len_a;
    assign op_len[1]   = in_len_b;
    assign op_ib_in[0] = in_ib_a;
    assign op_ib_in[1] = in_ib_b;
    assign op_guard[0] = in_guard_a;
    assign op_guard[1] = in_guard_b;
    assign op_mant[0]  = in_mant_a;
    assign op_mant[1]  = in_mant_b;

    assign in_ready  = (state_q == ST_IDLE);
    assign out_valid = (state_q == ST_HOLD);
    assign accept    = in_valid && in_ready;

    assign n_in    = LEN_W'(wider_len(32'(in_len_a), 32'(in_len_b)));
    assign lout_in = LEN_W'(clamp_len(32'(n_in), 32'(in_wp)));

    for (genvar g = 0; g < 2; g++) begin : g_op
        csa_opbuf #(
            .CHUNK_W(CHUNK_W), .MAX_CHUNKS(MAX_CHUNKS), .IB_W(IB_W),
            .GUARD_W(GUARD_W), .LEN_W(LEN_W)
        ) buf_i (
            .clk      (clk),
            .rst      (rst),
            .load     (accept),
            .ld_len   (op_len[g]),
            .ld_ib    (op_ib_in[g]),
            .ld_guard (op_guard[g]),
            .ld_mant  (op_mant[g]),
            .slot     (slot_q),
            .col      (op_col[g]),
            .ib       (op_ib[g])
        );
    end

    csa_colsum #(.W(CHUNK_W)) sum_i (
        .a    (op_col[0]),
        .b    (op_col[1]),
        .cin  (carry_q),
        .sub  (sub_q),
        .sum  (col_sum),
        .cout (col_cout)
    );

    // Integer bits absorb the carry (or no-borrow) out of chunk 0.
    assign ib_sum  = op_ib[0] + (sub_q ? ~op_ib[1] : op_ib[1]) + IB_W'(col_cout);
    assign discard = (slot_q >= lout_q);
    assign res_we  = (state_q == ST_RUN) && !discard;

    csa_resbuf #(
        .CHUNK_W(CHUNK_W), .MAX_CHUNKS(MAX_CHUNKS), .LEN_W(LEN_W)
    ) res_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .we    (res_we),
        .slot  (slot_q),
        .data  (col_sum),
        .flat  (out_mant)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            slot_q   <= '0;
            lout_q   <= '0;
            sub_q    <= 1'b0;
            carry_q  <= 1'b0;
            guard_q  <= '0;
            sticky_q <= 1'b0;
            ib_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (in_valid) begin
                        sub_q    <= in_sub;
                        carry_q  <= in_sub;   // +1 completes the two's complement
                        slot_q   <= n_in;     // start at the guard column
                        lout_q   <= lout_in;
                        guard_q  <= '0;
                        sticky_q <= 1'b0;
                        state_q  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    carry_q <= col_cout;
                    if (discard) begin
                        sticky_q <= sticky_q | (|guard_q) | (|col_sum[LOW_W-1:0]);
                        guard_q  <= col_sum[CHUNK_W-1 -: GUARD_W];
                    end
                    if (slot_q == '0) begin
                        ib_q    <= ib_sum;
                        state_q <= ST_HOLD;
                    end else begin
                        slot_q <= slot_q - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (out_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign out_len    = lout_q;
    assign out_ib     = ib_q;
    assign out_guard  = guard_q;
    assign out_sticky = sticky_q;

endmodule

// File: rtl/csa_chk.sv
module csa_chk #(
    parameter int unsigned IB_W    = 2,
    parameter int unsigned GUARD_W = 8,
    parameter int unsigned LEN_W   = 4,
    parameter int unsigned MANT_W  = 512,
    parameter int unsigned MAX_LEN = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LEN_W-1:0]   out_len,
    input logic [IB_W-1:0]    out_ib,
    input logic [GUARD_W-1:0] out_guard,
    input logic               out_sticky,
    input logic [MANT_W-1:0]  out_mant
);
    // R8: accepting and presenting never overlap
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R8: a stalled result stays put and blocks new input
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && !in_ready && $stable(out_mant)
            && $stable(out_len) && $stable(out_ib) && $stable(out_guard)
            && $stable(out_sticky)));

    // R9: handshake on the output frees the input next cycle
    p_release_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |=> (in_ready && !out_valid));

    // R7: at least one column step separates acceptance from the result
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && !out_valid));

    // R5: a presented length is within 1..MAX_LEN
    p_len_range_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_len != '0) && (32'(out_len) <= MAX_LEN)));

endmodule

bind chunk_serial_adder csa_chk #(
    .IB_W(IB_W), .GUARD_W(GUARD_W), .LEN_W(LEN_W), .MANT_W(MANT_W),
    .MAX_LEN(MAX_CHUNKS)
) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
    .out_ib(out_ib), .out_guard(out_guard), .out_sticky(out_sticky),
    .out_mant(out_mant)
);

// File: tb/chunk_serial_adder_tb_top.sv
`timescale 1ns/1ps
module chunk_serial_adder_tb_top;
    localparam int CW  = 64;
    localparam int MC  = 8;
    localparam int IBW = 2;
    localparam int GW  = 8;
    localparam int LW  = 4;
    localparam int MW  = CW * MC;
    localparam int VW  = IBW + CW * (MC + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_ready, in_sub, out_valid, out_ready, out_sticky;
    logic [LW-1:0] in_wp, in_len_a, in_len_b, out_len;
    logic [IBW-1:0] in_ib_a, in_ib_b, out_ib;
    logic [GW-1:0] in_guard_a, in_guard_b, out_guard;
    logic [MW-1:0] in_mant_a, in_mant_b, out_mant;

    int checks = 0;
    int errors = 0;
    int rdy_mode = 0;
    string cur_tag = "R2";

    // model state
    bit            m_busy = 0;
    int            m_cnt = 0;
    string         m_tag;
    logic [LW-1:0] e_len;
    logic [IBW-1:0] e_ib;
    logic [GW-1:0] e_guard;
    logic          e_sticky;
    logic [MW-1:0] e_mant;

    always #5 clk = ~clk;

    chunk_serial_adder dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_sub(in_sub), .in_wp(in_wp), .in_len_a(in_len_a), .in_len_b(in_len_b),
        .in_ib_a(in_ib_a), .in_ib_b(in_ib_b), .in_guard_a(in_guard_a),
        .in_guard_b(in_guard_b), .in_mant_a(in_mant_a), .in_mant_b(in_mant_b),
        .out_valid(out_valid), .out_ready(out_ready), .out_len(out_len),
        .out_ib(out_ib), .out_guard(out_guard), .out_sticky(out_sticky),
        .out_mant(out_mant)
    );

    task automatic check(input bit ok, input string req, input logic [MW-1:0] act,
                         input logic [MW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Operand as one wide number: integer bits, slots 0..MC, guard below last chunk.
    function automatic logic [VW-1:0] build(int len, logic [IBW-1:0] ib,
                                            logic [GW-1:0] g, logic [MW-1:0] m);
        logic [VW-1:0] v;
        v = '0;
        v[VW-1 -: IBW] = ib;
        for (int s = 0; s < len; s++) v[VW-IBW-1-CW*s -: CW] = m[s*CW +: CW];
        v[VW-IBW-1-CW*len -: GW] = g;
        return v;
    endfunction

    function automatic logic [MW-1:0] rnd_mant();
        logic [MW-1:0] m;
        for (int k = 0; k < MW/32; k++) m[k*32 +: 32] = $urandom;
        return m;
    endfunction

    // Expected result computed from the requirements at acceptance time.
    task automatic model_accept();
        logic [VW-1:0] a, b, r, t;
        int n, lim, lo;
        a = build(int'(in_len_a), in_ib_a, in_guard_a, in_mant_a);
        b = build(int'(in_len_b), in_ib_b, in_guard_b, in_mant_b);
        r = in_sub ? (a - b) : (a + b);
        n = (in_len_a > in_len_b) ? int'(in_len_a) : int'(in_len_b);
        lim = (in_wp == 0) ? 1 : int'(in_wp);
        lo = (n < lim) ? n : lim;
        e_len = LW'(lo);
        e_ib = r[VW-1 -: IBW];
        e_mant = '0;
        for (int s = 0; s < lo; s++) e_mant[s*CW +: CW] = r[VW-IBW-1-CW*s -: CW];
        e_guard = r[VW-IBW-1-CW*lo -: GW];
        t = r << (IBW + CW*lo + GW);
        e_sticky = |t;
        m_cnt = n + 1;
        m_busy = 1;
        m_tag = cur_tag;
    endtask

    // Cycle model, sampled at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                m_busy = 0;
                m_cnt = 0;
            end else begin
                check(in_ready == !m_busy, "R9", in_ready, !m_busy);
                check(out_valid == (m_busy && m_cnt == 0), "R7", out_valid, m_busy && m_cnt == 0);
                if (m_busy && m_cnt == 0 && out_valid) begin
                    check(out_len == e_len, "R5", out_len, e_len);
                    check(out_mant == e_mant, m_tag, out_mant, e_mant);
                    check(out_ib == e_ib, "R2", out_ib, e_ib);
                    check(out_guard == e_guard, "R6", out_guard, e_guard);
                    check(out_sticky == e_sticky, "R6", out_sticky, e_sticky);
                    if (!out_ready) check(!in_ready, "R8", in_ready, 0);
                end
                if (out_valid && out_ready) m_busy = 0;
                if (in_valid && in_ready) model_accept();
                else if (m_busy && m_cnt > 0) m_cnt--;
            end
        end
    end

    // Downstream ready pattern.
    initial begin
        out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = ($urandom % 3) != 0;
                default: out_ready = ($urandom % 8) == 0;
            endcase
        end
    end

    task automatic issue(input bit sub, input int la, input int lb,
                         input logic [IBW-1:0] ia, input logic [IBW-1:0] ib,
                         input logic [GW-1:0] ga, input logic [GW-1:0] gb,
                         input logic [MW-1:0] ma, input logic [MW-1:0] mb, input int wp);
        @(posedge clk);
        #1;
        in_valid = 1'b1; in_sub = sub; in_len_a = LW'(la); in_len_b = LW'(lb);
        in_ib_a = ia; in_ib_b = ib; in_guard_a = ga; in_guard_b = gb;
        in_mant_a = ma; in_mant_b = mb; in_wp = LW'(wp);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        // R5: scramble inputs after acceptance; result must not change
        in_valid = 1'b0;
        in_wp = LW'($urandom);
        in_mant_a = rnd_mant();
        in_mant_b = rnd_mant();
        in_len_a = LW'(1 + $urandom % MC);
        in_sub = ~in_sub;
    endtask

    initial begin
        logic [MW-1:0] ones, one_lsb, lead;
        rst = 1'b1;
        in_valid = 0; in_sub = 0; in_wp = 0; in_len_a = 1; in_len_b = 1;
        in_ib_a = 0; in_ib_b = 0; in_guard_a = 0; in_guard_b = 0;
        in_mant_a = '0; in_mant_b = '0;
        repeat (2) @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 2'b10);
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1 && out_valid == 1'b0, "R1", {in_ready, out_valid}, 2'b10);

        // R2: full length add
        cur_tag = "R2";
        issue(0, 8, 8, 1, 1, 8'h3c, 8'hc5, rnd_mant(), rnd_mant(), 8);
        // R2: carry ripples from the guard column through every chunk into IB
        ones = '1;
        one_lsb = '0;
        issue(0, 8, 8, 1, 1, 8'hff, 8'h01, ones, one_lsb, 8);
        // R2: single chunk
        issue(0, 1, 1, 1, 1, 8'h80, 8'h80, rnd_mant(), rnd_mant(), 1);
        // R3: borrow chain below a leading one
        cur_tag = "R3";
        lead = '0;
        issue(1, 8, 8, 2, 0, 8'h00, 8'h01, lead, lead, 8);
        issue(1, 5, 5, 3, 1, 8'h10, 8'h20, rnd_mant(), rnd_mant(), 5);
        // R4: unequal lengths, guard lands inside the other operand's column
        cur_tag = "R4";
        issue(0, 3, 6, 1, 1, 8'haa, 8'h55, rnd_mant(), rnd_mant(), 8);
        issue(1, 7, 2, 2, 1, 8'hf0, 8'h0f, rnd_mant(), rnd_mant(), 8);
        // R5/R6: clamp below n, wp=0, wp above n
        cur_tag = "R6";
        issue(0, 7, 7, 1, 1, 8'h01, 8'h00, rnd_mant(), rnd_mant(), 2);
        issue(1, 8, 4, 2, 1, 8'h00, 8'h00, rnd_mant(), rnd_mant(), 0);
        issue(0, 2, 2, 1, 0, 8'h00, 8'h00, '0, '0, 6);
        issue(0, 4, 4, 1, 1, 8'h00, 8'h00, '0, '0, 3);

        // R8: random back-pressure with random traffic
        for (int mode = 1; mode <= 2; mode++) begin
            rdy_mode = mode;
            for (int i = 0; i < 25; i++) begin
                bit s;
                s = $urandom % 2;
                cur_tag = s ? "R3" : "R2";
                issue(s, 1 + $urandom % MC, 1 + $urandom % MC,
                      s ? IBW'(2 + $urandom % 2) : IBW'(1),
                      s ? IBW'($urandom % 2) : IBW'($urandom % 2),
                      GW'($urandom), GW'($urandom), rnd_mant(), rnd_mant(),
                      $urandom % 10);
            end
        end
        rdy_mode = 0;
        repeat (20) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule